// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block guards a 36-bit word split into four 9-bit lanes. Lane i occupies bits [9i+8:9i]; its top bit (bit 8, 17, 26 or 35) carries parity and the lower eight bits carry data. A single parity-kind input picks odd or even parity. It applies to checking and to generation alike. In check mode the block compares each incoming lane against that parity kind. It pulls an active-low error flag down when any lane that is marked valid fails.

A set of four parity trees does both jobs. During a mailbox read with generation enabled, the trees take the outgoing mailbox word instead of the incoming bus. Each outgoing lane keeps its eight data bits and receives a freshly computed parity bit in its top position. While this happens the error flag is held high whatever the bus carries. When generation is not active the outgoing word is the mailbox word, untouched.

The datapath is combinational. A parameter adds one output register stage for timing closure. Bus direction control and tri-stating belong to the surrounding port logic.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane i is bits [9i+8:9i] with its parity bit at bit 9i+8. With odd_sel=1 a lane passes when its nine bits hold an odd number of ones. With odd_sel=0 it passes when they hold an even number.
- R2: Outside generation, err_n is 0 exactly when at least one lane with lane_valid[i]=1 fails the R1 rule, and is 1 otherwise.
- R3: A lane with lane_valid[i]=0 never drives err_n low, whatever its bits are; with lane_valid=4'b0000 err_n stays 1.
- R4: Generation is active only when cs_n=0, en=1, wr_dir=0 (0 means read, 1 means write), mbx_sel=1 and gen_en=1 all hold. If any one of them is missing, the bus is checked as in R2.
- R5: While generation is active, err_n is 1 regardless of bus_in and lane_valid.
- R6: While generation is active, each lane of gen_word carries the eight data bits of the same lane of mbx_data. Its top bit is set so that the nine lane bits satisfy the parity kind chosen by odd_sel.
- R7: While generation is not active, gen_word equals mbx_data bit for bit.
- R8: With REG_OUT=1, err_n and gen_word show the result for the inputs present at the previous rising clock edge. During reset they read err_n=1 and gen_word=0. With REG_OUT=0 the outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| cs_n | input | 1 | Active-low port select |
| en | input | 1 | Port transfer enable, active high |
| wr_dir | input | 1 | Transfer direction, 1 write, 0 read |
| mbx_sel | input | 1 | Selects the mailbox for the transfer |
| gen_en | input | 1 | Requests parity generation on mailbox reads |
| lane_valid | input | 4 | Per-lane mask of lanes that count toward the error flag |
| bus_in | input | 36 | Incoming word checked for parity |
| mbx_data | input | 36 | Outgoing mailbox word |
| err_n | output | 1 | Active-low parity error flag |
| gen_word | output | 36 | Outgoing word, parity rewritten when generation is active |

## Verification
The bench builds two copies of the block side by side with the default four lanes of eight data bits. One has REG_OUT=1 and the other REG_OUT=0, and both are driven by the same stimulus. That puts the one-cycle latency and reset value of the registered variant (R8) and the zero-latency combinational variant within reach in every cycle. Random words with parity repaired and then selectively broken, plus random qualifier combinations, reach single-lane failures, masked lanes and each missing qualifier of the generation condition.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_kind_e;

    typedef enum logic {
        MODE_CHECK = 1'b0,
        MODE_GEN   = 1'b1
    } lane_mode_e;

    function automatic logic [0:0] par_target(input par_kind_e kind);
        return (kind == PAR_ODD) ? 1'b1 : 1'b0;
    endfunction

endpackage

// File: rtl/lane_parity_mode.sv
module lane_parity_mode
    import lane_parity_pkg::*;
(
    input  logic       cs_n,
    input  logic       en,
    input  logic       wr_dir,
    input  logic       mbx_sel,
    input  logic       gen_en,
    output lane_mode_e mode
);

    logic port_read;

    always_comb begin
        port_read = !cs_n && en && !wr_dir;
        if (port_read && mbx_sel && gen_en) begin
            mode = MODE_GEN;
        end else begin
            mode = MODE_CHECK;
        end
    end

endmodule

// File: rtl/lane_parity_tree.sv
module lane_parity_tree
    import lane_parity_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W:0] lane,
    input  par_kind_e       kind,
    output logic            fail,
    output logic            par_bit
);

    logic data_xor;
    logic want;

    always_comb begin
        data_xor = ^lane[DATA_W-1:0];
        want     = par_target(kind);
        fail     = (data_xor ^ lane[DATA_W]) != want;
        par_bit  = data_xor ^ want;
    end

endmodule

// File: rtl/lane_parity_out.sv
module lane_parity_out #(
    parameter int  WORD_W  = 36,
    parameter bit  REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_n_d,
    input  logic [WORD_W-1:0] word_d,
    output logic              err_n_q,
    output logic [WORD_W-1:0] word_q
);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    err_n_q <= 1'b1;
                    word_q  <= '0;
                end else begin
                    err_n_q <= err_n_d;
                    word_q  <= word_d;
                end
            end
        end else begin : g_wire
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign err_n_q    = err_n_d;
            assign word_q     = word_d;
        end
    endgenerate

endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
    import lane_parity_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int DATA_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             odd_sel,
    input  logic                             cs_n,
    input  logic                             en,
    input  logic                             wr_dir,
    input  logic                             mbx_sel,
    input  logic                             gen_en,
    input  logic [LANES-1:0]                 lane_valid,
    input  logic [LANES*(DATA_W+1)-1:0]      bus_in,
    input  logic [LANES*(DATA_W+1)-1:0]      mbx_data,
    output logic                             err_n,
    output logic [LANES*(DATA_W+1)-1:0]      gen_word
);

    localparam int LANE_W = DATA_W + 1;
    localparam int WORD_W = LANES * LANE_W;

    lane_mode_e        mode;
    par_kind_e         kind;
    logic [WORD_W-1:0] tree_in;
    logic [LANES-1:0]  lane_fail;
    logic [LANES-1:0]  lane_par;
    logic [WORD_W-1:0] word_d;
    logic              err_n_d;

    lane_parity_mode u_mode (
        .cs_n    (cs_n),
        .en      (en),
        .wr_dir  (wr_dir),
        .mbx_sel (mbx_sel),
        .gen_en  (gen_en),
        .mode    (mode)
    );

    assign kind    = odd_sel ? PAR_ODD : PAR_EVEN;
    // One set of trees: fed by the bus when checking, by the mailbox when generating.
    assign tree_in = (mode == MODE_GEN) ? mbx_data : bus_in;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            lane_parity_tree #(.DATA_W(DATA_W)) u_tree (
                .lane    (tree_in[i*LANE_W +: LANE_W]),
                .kind    (kind),
                .fail    (lane_fail[i]),
                .par_bit (lane_par[i])
            );

            always_comb begin
                unique case (mode)
                    MODE_GEN:   word_d[i*LANE_W +: LANE_W] =
                                    {lane_par[i], mbx_data[i*LANE_W +: DATA_W]};
                    MODE_CHECK: word_d[i*LANE_W +: LANE_W] =
                                    mbx_data[i*LANE_W +: LANE_W];
                    default:    word_d[i*LANE_W +: LANE_W] =
                                    mbx_data[i*LANE_W +: LANE_W];
                endcase
            end
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_GEN:   err_n_d = 1'b1;
            MODE_CHECK: err_n_d = ~|(lane_fail & lane_valid);
            default:    err_n_d = 1'b1;
        endcase
    end

    lane_parity_out #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_n_d (err_n_d),
        .word_d  (word_d),
        .err_n_q (err_n),
        .word_q  (gen_word)
    );

endmodule

// File: rtl/lane_parity_checker.sv
module lane_parity_checker #(
    parameter int LANES   = 4,
    parameter int DATA_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        odd_sel,
    input logic                        cs_n,
    input logic                        en,
    input logic                        wr_dir,
    input logic                        mbx_sel,
    input logic                        gen_en,
    input logic [LANES-1:0]            lane_valid,
    input logic [LANES*(DATA_W+1)-1:0] bus_in,
    input logic [LANES*(DATA_W+1)-1:0] mbx_data,
    input logic                        err_n,
    input logic [LANES*(DATA_W+1)-1:0] gen_word
);

    localparam int LANE_W = DATA_W + 1;
    localparam int WORD_W = LANES * LANE_W;

    function automatic logic [WORD_W-1:0] data_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) m[i*LANE_W +: DATA_W] = '1;
        return m;
    endfunction

    function automatic logic all_lanes_kind(input logic [WORD_W-1:0] w, input logic odd);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (($countones(w[i*LANE_W +: LANE_W]) % 2 == 1) != odd) ok = 1'b0;
        end
        return ok;
    endfunction

    localparam logic [WORD_W-1:0] DMASK = data_mask();

    logic              d_ok, d_gen, d_odd;
    logic [LANES-1:0]  d_valid;
    logic [WORD_W-1:0] d_mbx;
    logic              gen_now;

    assign gen_now = !cs_n && en && !wr_dir && mbx_sel && gen_en;

    generate
        if (REG_OUT) begin : g_dly
            logic unused_bus;
            assign unused_bus = ^bus_in;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    d_ok <= 1'b0; d_gen <= 1'b0; d_odd <= 1'b0;
                    d_valid <= '0; d_mbx <= '0;
                end else begin
                    d_ok <= 1'b1; d_gen <= gen_now; d_odd <= odd_sel;
                    d_valid <= lane_valid; d_mbx <= mbx_data;
                end
            end
        end else begin : g_now
            logic unused_bus;
            assign unused_bus = ^bus_in;
            assign d_ok = 1'b1; assign d_gen = gen_now; assign d_odd = odd_sel;
            assign d_valid = lane_valid; assign d_mbx = mbx_data;
        end
    endgenerate

    p_gen_mask_r5: assert property (@(posedge clk) disable iff (!rst_n || !d_ok)
        d_gen |-> err_n);
    p_masked_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n || !d_ok)
        (d_valid == '0) |-> err_n);
    p_gen_data_kept_r6: assert property (@(posedge clk) disable iff (!rst_n || !d_ok)
        d_gen |-> ((gen_word & DMASK) == (d_mbx & DMASK)));
    p_gen_parity_r6: assert property (@(posedge clk) disable iff (!rst_n || !d_ok)
        d_gen |-> all_lanes_kind(gen_word, d_odd));
    p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n || !d_ok)
        !d_gen |-> (gen_word == d_mbx));

endmodule

bind lane_parity_unit lane_parity_checker #(
    .LANES(LANES), .DATA_W(DATA_W), .REG_OUT(REG_OUT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .cs_n(cs_n), .en(en),
    .wr_dir(wr_dir), .mbx_sel(mbx_sel), .gen_en(gen_en), .lane_valid(lane_valid),
    .bus_in(bus_in), .mbx_data(mbx_data), .err_n(err_n), .gen_word(gen_word)
);

// File: tb/lane_parity_unit_tb_top.sv
module lane_parity_unit_tb_top;

    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int W     = LANES * LW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic odd_sel = 0, cs_n = 1, en = 0, wr_dir = 1, mbx_sel = 0, gen_en = 0;
    logic [LANES-1:0] lane_valid = '1;
    logic [W-1:0] bus_in = '0, mbx_data = '0;
    logic err_r, err_c;
    logic [W-1:0] word_r, word_c;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lane_parity_unit #(.LANES(LANES), .DATA_W(8), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .cs_n(cs_n), .en(en),
        .wr_dir(wr_dir), .mbx_sel(mbx_sel), .gen_en(gen_en), .lane_valid(lane_valid),
        .bus_in(bus_in), .mbx_data(mbx_data), .err_n(err_r), .gen_word(word_r));

    lane_parity_unit #(.LANES(LANES), .DATA_W(8), .REG_OUT(1'b0)) dut_comb_i (
        .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .cs_n(cs_n), .en(en),
        .wr_dir(wr_dir), .mbx_sel(mbx_sel), .gen_en(gen_en), .lane_valid(lane_valid),
        .bus_in(bus_in), .mbx_data(mbx_data), .err_n(err_c), .gen_word(word_c));

    function automatic logic gen_on();
        return !cs_n && en && !wr_dir && mbx_sel && gen_en;
    endfunction

    function automatic logic exp_err();
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (lane_valid[i] && (($countones(bus_in[i*LW +: LW]) % 2 == 1) != odd_sel))
                bad = 1'b1;
        return gen_on() ? 1'b1 : !bad;
    endfunction

    function automatic logic [W-1:0] exp_word();
        logic [W-1:0] w;
        w = mbx_data;
        if (gen_on())
            for (int i = 0; i < LANES; i++)
                w[i*LW + 8] = ($countones(mbx_data[i*LW +: 8]) % 2 == 1) ? !odd_sel : odd_sel;
        return w;
    endfunction

    function automatic logic [W-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[W-1:0];
    endfunction

    function automatic logic [W-1:0] fix_parity(input logic [W-1:0] w, input logic odd);
        for (int i = 0; i < LANES; i++)
            w[i*LW + 8] = ($countones(w[i*LW +: 8]) % 2 == 1) ? !odd : odd;
        return w;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs already set; check combinational copy now, registered copy after the edge.
    task automatic step(input string req_err, input string req_word);
        logic e; logic [W-1:0] w;
        #2;
        e = exp_err(); w = exp_word();
        chk(req_err, {{(W-1){1'b0}}, err_c}, {{(W-1){1'b0}}, e});
        chk(req_word, word_c, w);
        @(posedge clk); #2;
        chk({req_err, " R8"}, {{(W-1){1'b0}}, err_r}, {{(W-1){1'b0}}, e});
        chk({req_word, " R8"}, word_r, w);
        @(negedge clk);
    endtask

    task automatic set_gen(input logic on);
        cs_n = !on; en = on; wr_dir = !on; mbx_sel = on; gen_en = on;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17_C0DE));
        repeat (3) @(negedge clk);
        chk("R8 reset err", {{(W-1){1'b0}}, err_r}, {{(W-1){1'b0}}, 1'b1});
        chk("R8 reset word", word_r, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zero word passes even, fails odd on every lane
        bus_in = '0; odd_sel = 0; step("R1 even zero", "R7");
        odd_sel = 1; step("R1 odd zero", "R7");
        // R1/R2: one lane broken, lane 2 parity bit at bit 26
        bus_in = fix_parity(36'h0_1234_5678, 1'b1); odd_sel = 1; step("R1 good odd", "R7");
        bus_in[26] = ~bus_in[26]; step("R2 lane2 bad", "R7");
        // R3: mask that lane, then mask all
        lane_valid = 4'b1011; step("R3 lane2 masked", "R7");
        bus_in = ~fix_parity(36'h0, 1'b1); lane_valid = 4'b0000; step("R3 all masked", "R7");
        lane_valid = 4'b1111;
        // R5/R6: generation with broken bus
        mbx_data = rnd_word(); set_gen(1); odd_sel = 0; step("R5 gen even", "R6 even");
        odd_sel = 1; step("R5 gen odd", "R6 odd");
        // R4: drop each qualifier in turn
        for (int q = 0; q < 5; q++) begin
            set_gen(1);
            case (q)
                0: cs_n = 1; 1: en = 0; 2: wr_dir = 1; 3: mbx_sel = 0; default: gen_en = 0;
            endcase
            step("R4 qualifier missing", "R4 R7");
        end

        for (int n = 0; n < 400; n++) begin
            odd_sel = $urandom() % 2;
            lane_valid = 4'($urandom());
            bus_in = rnd_word();
            if ($urandom() % 2) begin
                bus_in = fix_parity(bus_in, odd_sel);
                if ($urandom() % 2) bus_in[($urandom() % LANES) * LW + ($urandom() % LW)] ^= 1'b1;
            end
            mbx_data = rnd_word();
            if ($urandom() % 3 == 0) set_gen(1);
            else begin
                cs_n = $urandom() % 4 == 0; en = $urandom() % 4 != 0; wr_dir = $urandom() % 2;
                mbx_sel = $urandom() % 2; gen_en = $urandom() % 2;
            end
            if (gen_on()) step("R5 random", "R6 random");
            else step("R2 random", "R7 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1;
        $finish;
    end

endmodule